// File: doc/BRIEF.md
# Prescaled Up/Down Timer with Reload Buffering

This block is a general-purpose timer. A prescaler divides the input clock by (prescale + 1) and gives one tick to the main counter for each of its wraps. The main counter counts up or down between 0 and the active reload value. Each wrap produces a one-cycle update pulse that other logic on the chip can use as a periodic event. The event rate is therefore the clock divided by (prescale + 1) and then by (reload + 1).

Software reaches the block through a simple synchronous register port. A write happens on the rising edge where `wrEn` is high. A read is combinational from `addr`. The prescale value is always written to a buffer. The reload value goes to a buffer or straight to the active register, depending on a control bit. An update event copies the buffers into the active registers. An update event is either a counter wrap or a software command written to the event register.

Register map: address 0 is control, with bit 0 = run, bit 1 = count down, and bit 2 = reload buffering on. Address 1 is the event command, where bit 0 set requests an update. This register always reads 0. Address 2 is the counter. Address 3 is the prescale buffer. Address 4 is the reload buffer.

Top module: `ptim_top`

## Requirements
- R1: After reset, the control, counter, prescale and reload registers read 0 and `updPulse` is low.
- R2: While running, the counter advances exactly once every (active prescale + 1) clocks. The prescaler position never exceeds the active prescale value.
- R3: Counting up (control bit 1 = 0), the counter goes from the active reload value to 0 on a tick. `updPulse` is high for the one cycle after that edge.
- R4: Counting down (control bit 1 = 1), the counter goes from 0 to the reload value on a tick, and `updPulse` pulses in the same way.
- R5: With the run bit (control bit 0) clear, neither the counter nor the prescaler moves.
- R6: With control bit 2 set, a write to address 4 changes only the buffer. The counter keeps wrapping at the old reload value until the next update event, and after that event it uses the new value.
- R7: With control bit 2 clear, a write to address 4 takes effect on the active reload value at the same edge.
- R8: A write to address 3 does not change the counting rate until the next update event.
- R9: Writing address 1 with bit 0 set does the following at that edge: it loads both buffers into the active registers, restarts the prescaler, and does not advance the counter. It also pulses `updPulse` in the next cycle. A write with bit 0 clear does nothing, and address 1 reads 0.
- R10: A write to address 2 sets the counter at any time and takes priority over a tick at the same edge. Address 2 reads back the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| updPulse | output | 1 | One-cycle update event pulse |

## Verification
The wrap assertions assume that software never writes a count above the active reload value. If it did, an up-counter would wrap from a value other than the reload value. The stimulus always writes start counts no larger than the reload value in force. The checks also assume that the direction bit does not change in the cycle just before a wrap. The bench changes the direction only while the run bit is clear.

// File: rtl/ptim_pkg.sv
package ptim_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 3'd0,
    ADR_EVT  = 3'd1,
    ADR_CNT  = 3'd2,
    ADR_PSC  = 3'd3,
    ADR_ARR  = 3'd4
  } regAddr_t;

  localparam int CTL_RUN     = 0;
  localparam int CTL_DOWN    = 1;
  localparam int CTL_PRELOAD = 2;
  localparam int CTL_W       = 3;

  typedef struct packed {
    logic run;
    logic dirDown;
    logic cntWr;
    logic arrWrNow;
    logic swUpd;
  } tmrStrb_t;

endpackage

// File: rtl/ptim_ctrl.sv
module ptim_ctrl
  import ptim_pkg::*;
#(
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output tmrStrb_t              strb,
  output logic [CTL_W-1:0]      ctrlBits,
  output logic [PSC_W-1:0]      pscBuf,
  output logic [CNT_W-1:0]      arrBuf
);

  logic runQ, downQ, preloadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      downQ    <= 1'b0;
      preloadQ <= 1'b0;
      pscBuf   <= '0;
      arrBuf   <= '0;
    end else if (wrEn) begin
      case (addr)
        ADR_CTRL: begin
          runQ     <= wrData[CTL_RUN];
          downQ    <= wrData[CTL_DOWN];
          preloadQ <= wrData[CTL_PRELOAD];
        end
        ADR_PSC: pscBuf <= wrData[PSC_W-1:0];
        ADR_ARR: arrBuf <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.run      = runQ;
    strb.dirDown  = downQ;
    strb.cntWr    = wrEn && (addr == ADR_CNT);
    strb.arrWrNow = wrEn && (addr == ADR_ARR) && !preloadQ;
    strb.swUpd    = wrEn && (addr == ADR_EVT) && wrData[0];
  end

  assign ctrlBits = {preloadQ, downQ, runQ};

endmodule

// File: rtl/ptim_datapath.sv
module ptim_datapath
  import ptim_pkg::*;
#(
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrb_t           strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [PSC_W-1:0]   pscBuf,
  input  logic [CNT_W-1:0]   arrBuf,
  output logic [CNT_W-1:0]   cntVal,
  output logic [CNT_W-1:0]   arrAct,
  output logic [PSC_W-1:0]   pscAct,
  output logic [PSC_W-1:0]   preCnt,
  output logic               updPulse
);

  logic tick, wrapUp, wrapDn, hwUpd, updEvt;

  always_comb begin
    tick   = strb.run && !strb.swUpd && (preCnt == pscAct);
    wrapUp = tick && !strb.dirDown && (cntVal >= arrAct);
    wrapDn = tick && strb.dirDown && (cntVal == '0);
    hwUpd  = (wrapUp || wrapDn) && !strb.cntWr;
    updEvt = hwUpd || strb.swUpd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strb.swUpd) begin
      preCnt <= '0;
    end else if (strb.run) begin
      preCnt <= tick ? '0 : preCnt + PSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strb.cntWr) begin
      cntVal <= wrData[CNT_W-1:0];
    end else if (tick) begin
      if (strb.dirDown) cntVal <= wrapDn ? arrBuf : cntVal - CNT_W'(1);
      else              cntVal <= wrapUp ? '0 : cntVal + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrAct   <= '0;
      pscAct   <= '0;
      updPulse <= 1'b0;
    end else begin
      if (strb.arrWrNow)  arrAct <= wrData[CNT_W-1:0];
      else if (updEvt)    arrAct <= arrBuf;
      if (updEvt)         pscAct <= pscBuf;
      updPulse <= updEvt;
    end
  end

endmodule

// File: rtl/ptim_top.sv
module ptim_top
  import ptim_pkg::*;
#(
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              updPulse
);

  tmrStrb_t         strb;
  logic [CTL_W-1:0] ctrlBits;
  logic [PSC_W-1:0] pscBuf, pscAct, preCnt;
  logic [CNT_W-1:0] arrBuf, arrAct, cntVal;

  ptim_ctrl #(.PSC_W(PSC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .ctrlBits(ctrlBits), .pscBuf(pscBuf), .arrBuf(arrBuf)
  );

  ptim_datapath #(.PSC_W(PSC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .pscBuf(pscBuf), .arrBuf(arrBuf), .cntVal(cntVal), .arrAct(arrAct),
    .pscAct(pscAct), .preCnt(preCnt), .updPulse(updPulse)
  );

  always_comb begin
    case (addr)
      ADR_CTRL: rdData = DATA_W'(ctrlBits);
      ADR_CNT:  rdData = DATA_W'(cntVal);
      ADR_PSC:  rdData = DATA_W'(pscBuf);
      ADR_ARR:  rdData = DATA_W'(arrBuf);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/ptim_checker.sv
module ptim_checker #(
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              run,
  input logic              dirDown,
  input logic              cntWr,
  input logic              arrWrNow,
  input logic              swUpd,
  input logic [DATA_W-1:0] wrData,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  arrAct,
  input logic [PSC_W-1:0]  preCnt,
  input logic [PSC_W-1:0]  pscAct,
  input logic              updPulse
);

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rstN) preCnt <= pscAct); // R2
  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN) (!cntWr && !swUpd && !dirDown) ##1 updPulse |-> cntVal == '0); // R3
  AST_DN_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rstN) (!cntWr && !swUpd && dirDown) ##1 updPulse |-> cntVal == arrAct); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN) (!run && !cntWr) |=> $stable(cntVal)); // R5
  AST_ARR_THROUGH: assert property (@(posedge clk) disable iff (!rstN) arrWrNow |=> arrAct == $past(wrData[CNT_W-1:0])); // R7
  AST_SWUPD_PULSE: assert property (@(posedge clk) disable iff (!rstN) swUpd |=> updPulse); // R9
  AST_SWUPD_RESTART: assert property (@(posedge clk) disable iff (!rstN) swUpd |=> preCnt == '0); // R9

endmodule

bind ptim_top ptim_checker #(.PSC_W(PSC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .run(strb.run), .dirDown(strb.dirDown),
  .cntWr(strb.cntWr), .arrWrNow(strb.arrWrNow), .swUpd(strb.swUpd),
  .wrData(wrData), .cntVal(cntVal), .arrAct(arrAct), .preCnt(preCnt),
  .pscAct(pscAct), .updPulse(updPulse)
);

// File: tb/ptim_top_tb.sv
module ptim_top_tb;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          updPulse;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  ptim_top #(.PSC_W(16), .CNT_W(16), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .updPulse(updPulse)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0]  psc;
    logic [7:0]  arr;
    logic        down;
    logic [7:0]  start;
    logic [15:0] waitCyc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{psc: 8'd0, arr: 8'd9, down: 1'b0, start: 8'd0, waitCyc: 16'd7},
    '{psc: 8'd0, arr: 8'd9, down: 1'b0, start: 8'd0, waitCyc: 16'd25},
    '{psc: 8'd2, arr: 8'd4, down: 1'b0, start: 8'd1, waitCyc: 16'd20},
    '{psc: 8'd0, arr: 8'd5, down: 1'b1, start: 8'd3, waitCyc: 16'd10},
    '{psc: 8'd3, arr: 8'd2, down: 1'b1, start: 8'd2, waitCyc: 16'd17},
    '{psc: 8'd1, arr: 8'd0, down: 1'b0, start: 8'd0, waitCyc: 16'd6}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic wr(input logic [2:0] a, input int d);
    wrEn = 1'b1; addr = a; wrData = DW'(d);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int v, v0, pulses, ticks, m, expCnt, expWraps;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd2, v); check("R1 cnt", v, 0);
    rd(3'd3, v); check("R1 psc", v, 0);
    rd(3'd4, v); check("R1 arr", v, 0);
    check("R1 pulse", int'(updPulse), 0);

    // R7 write-through reload, R3 up wrap, R5 hold
    wr(3'd0, 0); wr(3'd3, 0); wr(3'd4, 20); wr(3'd1, 1);
    wr(3'd2, 4); wr(3'd4, 5); wr(3'd0, 1);
    waitCyc(1); rd(3'd2, v); check("R7 cnt", v, 5);
    waitCyc(1); rd(3'd2, v); check("R7 wrap at new reload", v, 0);
    check("R3 pulse", int'(updPulse), 1);
    wr(3'd0, 0); rd(3'd2, v0);
    waitCyc(10); rd(3'd2, v); check("R5 hold", v, v0);
    check("R5 no pulse", int'(updPulse), 0);

    // R6 buffered reload
    wr(3'd0, 4); wr(3'd3, 0); wr(3'd4, 3); wr(3'd1, 1);
    wr(3'd2, 3); wr(3'd4, 9); wr(3'd0, 5);
    waitCyc(1); rd(3'd2, v); check("R6 old reload wrap", v, 0);
    check("R6 pulse", int'(updPulse), 1);
    waitCyc(9); rd(3'd2, v); check("R6 new reload used", v, 9);
    waitCyc(1); rd(3'd2, v); check("R6 wrap at new", v, 0);
    rd(3'd4, v); check("R6 arr readback", v, 9);

    // R8 prescale buffered, R9 software update
    wr(3'd0, 0); wr(3'd3, 0); wr(3'd4, 100); wr(3'd1, 1);
    wr(3'd3, 3); wr(3'd2, 0); wr(3'd0, 1);
    waitCyc(4); rd(3'd2, v); check("R8 old rate", v, 4);
    wr(3'd1, 1);
    check("R9 pulse", int'(updPulse), 1);
    rd(3'd2, v); check("R9 no advance", v, 4);
    waitCyc(3); rd(3'd2, v); check("R8 new rate hold", v, 4);
    waitCyc(1); rd(3'd2, v); check("R8 new rate tick", v, 5);
    rd(3'd1, v); check("R9 evt reads 0", v, 0);
    wr(3'd1, 0); check("R9 bit0 clear no pulse", int'(updPulse), 0);

    // R10 counter write while running
    wr(3'd2, 50); rd(3'd2, v); check("R10 cnt write", v, 50);

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 0);
      wr(3'd3, int'(VECS[i].psc));
      wr(3'd4, int'(VECS[i].arr));
      wr(3'd1, 1);
      wr(3'd2, int'(VECS[i].start));
      wr(3'd0, 1 + (VECS[i].down ? 2 : 0));
      pulses = 0;
      for (int c = 0; c < int'(VECS[i].waitCyc); c++) begin
        @(negedge clk);
        if (updPulse) pulses++;
      end
      ticks = int'(VECS[i].waitCyc) / (int'(VECS[i].psc) + 1);
      m = int'(VECS[i].arr) + 1;
      if (!VECS[i].down) begin
        expCnt = (int'(VECS[i].start) + ticks) % m;
        expWraps = (int'(VECS[i].start) + ticks) / m;
      end else begin
        expCnt = ((int'(VECS[i].start) - ticks) % m + m) % m;
        expWraps = (ticks > int'(VECS[i].start)) ?
                   1 + (ticks - int'(VECS[i].start) - 1) / m : 0;
      end
      rd(3'd2, v);
      check(VECS[i].down ? "R4 R2 count" : "R3 R2 count", v, expCnt);
      check(VECS[i].down ? "R4 pulses" : "R3 pulses", pulses, expWraps);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule